// File: doc/BRIEF.md
# Fast Context Switch Address Modifier

This block sits between a processor core's virtual address output and the caches and memory management unit. It holds a 7-bit process slot number. Every address the core issues in the lowest 32 MB window is relocated into one of 128 slots of 32 MB each. The slot number is placed in the top seven address bits. Several processes linked to run from address zero can then share caches and translation tables without flushing them on a switch: software only writes a new slot number.

Relocation is skipped in three cases: the address already lies at or above 32 MB, address translation is disabled, or the address belongs to a cache or TLB maintenance operation that targets a single entry. The slot register is written through a 32-bit word in which the slot number occupies bits [31:25]. A read port returns the same layout. The address path is combinational from the current register value, so the modified address is valid in the same cycle as the virtual address.

The block has no state machine. Its only state is the slot register, which has two behaviours: it holds its value, or it loads a new value on a write.

Top module: `fcse_remap`

## Requirements
- R1: With translation enabled, the maintenance flag low, and `va_i[31:25]` equal to zero, `mva_o` equals `{slot, va_i[24:0]}`. This equals va + slot × 32 MB.
- R2: When `va_i[31:25]` is non-zero, `mva_o` equals `va_i` for any slot value. This includes the boundary address 0x0200_0000.
- R3: With a slot value of zero, `mva_o` equals `va_i` for every address.
- R4: After reset the slot value is zero. `slot_rdata_o` reads 0 and low addresses pass unchanged.
- R5: When `mmu_en_i` is low, `mva_o` equals `va_i`.
- R6: When `maint_i` is high, `mva_o` equals `va_i`.
- R7: When `slot_we_i` is high at a rising clock edge, the slot register loads `slot_wdata_i[31:25]`, and bits [24:0] of the write data are ignored. Addresses presented in the cycle of the write still use the old value. The new value applies from the next cycle on.
- R8: `slot_rdata_o` carries the slot value in bits [31:25] and zeros in bits [24:0].
- R9: When `slot_we_i` is low, the slot value does not change, whatever `slot_wdata_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| va_i | input | 32 | Virtual address from the core |
| mmu_en_i | input | 1 | High when address translation is enabled |
| maint_i | input | 1 | High when the address is the operand of an entry-based cache or TLB maintenance operation |
| slot_we_i | input | 1 | Slot register write strobe |
| slot_wdata_i | input | 32 | Write word; slot number in bits [31:25] |
| slot_rdata_o | output | 32 | Slot number in bits [31:25], zeros elsewhere |
| mva_o | output | 32 | Modified virtual address |

## Verification
The embedded properties check the following on every cycle:
- High addresses pass through unchanged.
- Both bypass conditions hold.
- The low 25 bits are always preserved.
- Relocated addresses carry exactly the value that the read port shows.
- A write lands one cycle later, and the register holds when no write is made.

Only the bench scenarios can show the zero value after reset and the exact cycle in which a write becomes visible to a lookup. They also confirm the concrete relocated values at the edges of the 32 MB window for slot values 0, 1, 5, 42 and 127.

// File: rtl/fcse_pkg.sv
package fcse_pkg;
    parameter int ADDR_W   = 32;
    parameter int SLOT_LSB = 25;
    localparam int SLOT_W  = ADDR_W - SLOT_LSB;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/fcse_slot_reg.sv
module fcse_slot_reg #(
    parameter int ADDR_W   = fcse_pkg::ADDR_W,
    parameter int SLOT_LSB = fcse_pkg::SLOT_LSB
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [ADDR_W-1:0]            wdata_i,
    output logic [ADDR_W-SLOT_LSB-1:0]   slot_o,
    output logic [ADDR_W-1:0]            rdata_o
);
    localparam int SLOT_W = ADDR_W - SLOT_LSB;

    logic [SLOT_W-1:0] slot_q;

    // Slot register: hold or load, reset to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (we_i) begin
            slot_q <= wdata_i[ADDR_W-1:SLOT_LSB];
        end
    end

    always_comb begin
        slot_o  = slot_q;
        rdata_o = {slot_q, {SLOT_LSB{1'b0}}};
    end

    // R7: a write lands in the register by the next cycle
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (slot_o == $past(wdata_i[ADDR_W-1:SLOT_LSB])));

    // R9: without a write the value holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(slot_o));
endmodule

// File: rtl/fcse_addr_remap.sv
module fcse_addr_remap #(
    parameter int ADDR_W   = fcse_pkg::ADDR_W,
    parameter int SLOT_LSB = fcse_pkg::SLOT_LSB
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            va_i,
    input  logic                         mmu_en_i,
    input  logic                         maint_i,
    input  logic [ADDR_W-SLOT_LSB-1:0]   slot_i,
    output logic [ADDR_W-1:0]            mva_o
);
    localparam int SLOT_W = ADDR_W - SLOT_LSB;

    logic in_low_window;
    logic relocate;

    always_comb begin
        in_low_window = (va_i[ADDR_W-1:SLOT_LSB] == '0);
        relocate      = in_low_window && mmu_en_i && !maint_i;
        // The upper field is zero in the low window, so the add reduces to a merge.
        mva_o         = relocate ? {slot_i, va_i[SLOT_LSB-1:0]} : va_i;
    end

    // R2: addresses at or above the window pass unchanged
    p_high_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (va_i[ADDR_W-1:SLOT_LSB] != '0) |-> (mva_o == va_i));

    // R5: translation disabled bypasses relocation
    p_mmu_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mmu_en_i |-> (mva_o == va_i));

    // R6: maintenance operands bypass relocation
    p_maint_r6: assert property (@(posedge clk) disable iff (!rst_n)
        maint_i |-> (mva_o == va_i));

    // R1: offset inside the slot is always preserved
    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mva_o[SLOT_LSB-1:0] == va_i[SLOT_LSB-1:0]);
endmodule

// File: rtl/fcse_remap.sv
module fcse_remap #(
    parameter int ADDR_W   = fcse_pkg::ADDR_W,
    parameter int SLOT_LSB = fcse_pkg::SLOT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] va_i,
    input  logic              mmu_en_i,
    input  logic              maint_i,
    input  logic              slot_we_i,
    input  logic [ADDR_W-1:0] slot_wdata_i,
    output logic [ADDR_W-1:0] slot_rdata_o,
    output logic [ADDR_W-1:0] mva_o
);
    localparam int SLOT_W = ADDR_W - SLOT_LSB;

    logic [SLOT_W-1:0] slot_cur;

    fcse_slot_reg #(.ADDR_W(ADDR_W), .SLOT_LSB(SLOT_LSB)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (slot_we_i),
        .wdata_i (slot_wdata_i),
        .slot_o  (slot_cur),
        .rdata_o (slot_rdata_o)
    );

    fcse_addr_remap #(.ADDR_W(ADDR_W), .SLOT_LSB(SLOT_LSB)) u_remap (
        .clk      (clk),
        .rst_n    (rst_n),
        .va_i     (va_i),
        .mmu_en_i (mmu_en_i),
        .maint_i  (maint_i),
        .slot_i   (slot_cur),
        .mva_o    (mva_o)
    );

    // R1/R8: a relocated address carries the slot value shown on the read port
    p_slot_matches_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mmu_en_i && !maint_i && va_i[ADDR_W-1:SLOT_LSB] == '0)
            |-> (mva_o[ADDR_W-1:SLOT_LSB] == slot_rdata_o[ADDR_W-1:SLOT_LSB]));

    // R8: read word carries zeros below the slot field
    p_read_format_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rdata_o[SLOT_LSB-1:0] == '0);
endmodule

// File: tb/fcse_remap_tb_top.sv
module fcse_remap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] va_i = '0;
    logic        mmu_en_i = 1'b0;
    logic        maint_i = 1'b0;
    logic        slot_we_i = 1'b0;
    logic [31:0] slot_wdata_i = '0;
    logic [31:0] slot_rdata_o;
    logic [31:0] mva_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fcse_remap dut_i (
        .clk(clk), .rst_n(rst_n), .va_i(va_i), .mmu_en_i(mmu_en_i),
        .maint_i(maint_i), .slot_we_i(slot_we_i), .slot_wdata_i(slot_wdata_i),
        .slot_rdata_o(slot_rdata_o), .mva_o(mva_o)
    );

    // Vector: [72:66] slot, [65] mmu_en, [64] maint, [63:32] va, [31:0] expected mva
    localparam int NV = 10;
    localparam logic [72:0] VEC [NV] = '{
        {7'h00, 1'b1, 1'b0, 32'h0123_4567, 32'h0123_4567},  // R3
        {7'h01, 1'b1, 1'b0, 32'h0000_1000, 32'h0200_1000},  // R1
        {7'h7F, 1'b1, 1'b0, 32'h01FF_FFFF, 32'hFFFF_FFFF},  // R1 top slot
        {7'h05, 1'b1, 1'b0, 32'h0200_0000, 32'h0200_0000},  // R2 boundary
        {7'h05, 1'b1, 1'b0, 32'h01FF_FFFC, 32'h0BFF_FFFC},  // R1
        {7'h05, 1'b0, 1'b0, 32'h0000_0040, 32'h0000_0040},  // R5
        {7'h05, 1'b1, 1'b1, 32'h0000_0040, 32'h0000_0040},  // R6
        {7'h2A, 1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000},  // R2
        {7'h2A, 1'b1, 1'b0, 32'h0000_0000, 32'h5400_0000},  // R1
        {7'h2A, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}   // R5 R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_slot(input logic [6:0] s, input logic [24:0] junk);
        @(negedge clk);
        slot_we_i    = 1'b1;
        slot_wdata_i = {s, junk};
        @(negedge clk);
        slot_we_i    = 1'b0;
        slot_wdata_i = 32'hDEAD_BEEF;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        va_i = 32'h0000_0100; mmu_en_i = 1'b1; maint_i = 1'b0;
        #1;
        check("R4 rdata", slot_rdata_o, 32'h0);
        check("R4 mva", mva_o, 32'h0000_0100);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 after release", slot_rdata_o, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            write_slot(VEC[i][72:66], 25'h1FF_FFFF);  // R7 low write bits ignored
            va_i = VEC[i][63:32]; mmu_en_i = VEC[i][65]; maint_i = VEC[i][64];
            #1;
            check("R1/R2/R3/R5/R6 vector mva", mva_o, VEC[i][31:0]);
            check("R8 read word", slot_rdata_o, {VEC[i][72:66], 25'h0});
        end

        // R7: write cycle still uses the old slot, next cycle the new one
        write_slot(7'h2A, 25'h0);
        @(negedge clk);
        va_i = 32'h0000_0010; mmu_en_i = 1'b1; maint_i = 1'b0;
        slot_we_i = 1'b1; slot_wdata_i = {7'h03, 25'h155_5555};
        #1;
        check("R7 same cycle old", mva_o, 32'h5400_0010);
        @(negedge clk);
        slot_we_i = 1'b0;
        #1;
        check("R7 next cycle new", mva_o, 32'h0600_0010);

        // R9: no write, changing data, value holds
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            slot_wdata_i = {7'h7F - 7'(k), 25'h0};
            #1;
            check("R9 hold", slot_rdata_o, {7'h03, 25'h0});
        end

        // R4: reset mid-run clears the slot
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R4 mid reset rdata", slot_rdata_o, 32'h0);
        check("R4 mid reset mva", mva_o, 32'h0000_0010);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule